// File: doc/BRIEF.md
# Programmable Parallel Port Controller

A host-side parallel I/O controller with three 8-bit ports (A, B, C) and one control register, reached over a synchronous 8-bit register bus qualified by an active-low select and a 2-bit address. A control word puts each port in plain latched output or live input mode, or in a strobed handshake mode. Port A alone can also run a bidirectional handshake. When a port runs a handshake, some port C pins stop being general I/O and carry that port's strobe, acknowledge, buffer flags and interrupt request. A control-register write with bit 7 clear does not change the mode. It sets or clears a single port C line, and the same command programs the internal interrupt-enable flags.

Pad buffers are modelled as separate input, output and output-enable vectors per port. Bus reads are combinational within the access cycle. Their side effects, such as clearing handshake flags, take effect at the closing clock edge. Handshake pins on port C are sampled synchronously to the block clock.

Top module: `ppi_ctrl`

## Requirements
- R1: After reset every output enable is 0, every output latch is 0, and rdata_o is 0.
- R2: While cs_ni is 1, bus writes change no latch or mode, and rdata_o reads 0.
- R3: Address 0 selects port A, 1 port B, 2 port C and 3 the control register. A read of address 3 returns 0xFF.
- R4: A control write with bit 7 = 1 sets the mode: [6:5] port A mode (00 plain, 01 strobed, 1x bidirectional), [4] port A input, [3] PC7..PC4 input, [2] port B strobed, [1] port B input, [0] PC3..PC0 input. It clears all output latches and interrupt enables.
- R5: A control write with bit 7 = 0 writes bit [0] into port C line [3:1] and leaves the mode unchanged.
- R6: In plain mode an output port drives its latch and reads it back. An input port reads the live pins. The port C halves follow their own direction bits.
- R7: Port A strobed input uses PC4 as the active-low strobe, PC5 as the buffer-full output and PC3 as the interrupt output. A low strobe loads the pins and sets buffer-full. A strobe rise with enable (PC4 command) set raises the interrupt. A read of port A clears both.
- R8: Port A strobed output drives its latch. A port A write drives PC7 (buffer full, active low) to 0 and clears the PC3 interrupt. A low on PC6 (acknowledge) returns PC7 to 1. An acknowledge rise with enable (PC6 command) set raises PC3.
- R9: In strobed mode port B uses PC2 as strobe or acknowledge, PC1 as buffer-full (input) or active-low buffer-full (output) and PC0 as interrupt. The PC2 command sets its enable.
- R10: In bidirectional mode port A drives its pins only while PC6 is low, latches input on a PC4 strobe, and uses PC3..PC7 for handshake.
- R11: A port C read returns at handshake positions the status flags, and the enable flag at each strobe or acknowledge position.
- R12: Ports A and B operate in different modes at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe for one cycle |
| rd_i | input | 1 | Read strobe for one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the read cycle |
| pa_i | input | 8 | Port A pad input |
| pa_o | output | 8 | Port A pad output |
| pa_oe_o | output | 8 | Port A output enable |
| pb_i | input | 8 | Port B pad input |
| pb_o | output | 8 | Port B pad output |
| pb_oe_o | output | 8 | Port B output enable |
| pc_i | input | 8 | Port C pad input |
| pc_o | output | 8 | Port C pad output |
| pc_oe_o | output | 8 | Port C output enable |

## Verification
The bench checks that a strobe with the enable cleared sets buffer-full but never raises the interrupt. A design that ties the interrupt to the strobe alone fails this check. It checks that a mode rewrite drops an enable that was set before. It checks that bidirectional port A lets go of its pins the cycle acknowledge returns high; a design that kept driving would fight the external device. Port C readback is compared bit for bit with handshake status mixed with latched and live bits, so a design that returns raw pins at handshake positions is caught. Bit set/reset commands are checked to leave directions untouched.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_PA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_PB  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_PC  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTL = 2'd3;

  typedef enum logic [1:0] {
    GA_SIMPLE  = 2'b00,
    GA_STROBED = 2'b01,
    GA_BIDIR   = 2'b10
  } ga_mode_e;

  typedef struct packed {
    ga_mode_e a_mode;
    logic     a_in;
    logic     ch_in;
    logic     b_strobed;
    logic     b_in;
    logic     cl_in;
  } mode_t;

  localparam mode_t MODE_RESET = '{a_mode: GA_SIMPLE, a_in: 1'b1, ch_in: 1'b1,
                                   b_strobed: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic mode_t decode_mode(input logic [PORT_W-1:0] w);
    mode_t m;
    m.a_mode    = w[6] ? GA_BIDIR : (w[5] ? GA_STROBED : GA_SIMPLE);
    m.a_in      = w[4];
    m.ch_in     = w[3];
    m.b_strobed = w[2];
    m.b_in      = w[1];
    m.cl_in     = w[0];
    return m;
  endfunction
endpackage

// File: rtl/ppi_hs_chan.sv
// One handshake engine: input side (strobe) and output side (acknowledge).
module ppi_hs_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              in_en_i,
  input  logic              out_en_i,
  input  logic              stb_ni,
  input  logic              ack_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic              inte_in_i,
  input  logic              inte_out_i,
  output logic [DATA_W-1:0] in_q_o,
  output logic              ibf_o,
  output logic              obf_no,
  output logic              irq_in_o,
  output logic              irq_out_o
);
  logic stb_q, ack_q;
  logic stb_rise, ack_rise;

  assign stb_rise = !stb_q && stb_ni;
  assign ack_rise = !ack_q && ack_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q     <= 1'b1;
      ack_q     <= 1'b1;
      in_q_o    <= '0;
      ibf_o     <= 1'b0;
      obf_no    <= 1'b1;
      irq_in_o  <= 1'b0;
      irq_out_o <= 1'b0;
    end else begin
      stb_q <= stb_ni;
      ack_q <= ack_ni;
      if (clr_i) begin
        in_q_o    <= '0;
        ibf_o     <= 1'b0;
        obf_no    <= 1'b1;
        irq_in_o  <= 1'b0;
        irq_out_o <= 1'b0;
      end else begin
        if (in_en_i) begin
          if (host_rd_i) begin
            ibf_o    <= 1'b0;
            irq_in_o <= 1'b0;
          end
          // strobe events take priority over a coincident host read
          if (!stb_ni) begin
            in_q_o <= din_i;
            ibf_o  <= 1'b1;
          end
          if (stb_rise && inte_in_i) irq_in_o <= 1'b1;
        end else begin
          ibf_o    <= 1'b0;
          irq_in_o <= 1'b0;
        end
        if (out_en_i) begin
          if (host_wr_i) begin
            obf_no    <= 1'b0;
            irq_out_o <= 1'b0;
          end
          if (!ack_ni) obf_no <= 1'b1;
          if (ack_rise && inte_out_i) irq_out_o <= 1'b1;
        end else begin
          obf_no    <= 1'b1;
          irq_out_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ppi_portc_map.sv
// Port C pin ownership: plain I/O per half, overridden by handshake lines.
module ppi_portc_map
  import ppi_pkg::*;
(
  input  mode_t             mode_i,
  input  logic [PORT_W-1:0] pc_q_i,
  input  logic [PORT_W-1:0] pc_i,
  input  logic              ibf_a_i,
  input  logic              obf_na_i,
  input  logic              irq_a_i,
  input  logic              inte_a_in_i,
  input  logic              inte_a_out_i,
  input  logic              ibf_b_i,
  input  logic              obf_nb_i,
  input  logic              irq_b_i,
  input  logic              inte_b_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o,
  output logic [PORT_W-1:0] pc_rd_o
);
  localparam int unsigned HALF = PORT_W / 2;

  logic a_hs, a_hs_in, a_hs_out;

  assign a_hs     = mode_i.a_mode != GA_SIMPLE;
  assign a_hs_in  = (mode_i.a_mode == GA_STROBED && mode_i.a_in) || mode_i.a_mode == GA_BIDIR;
  assign a_hs_out = (mode_i.a_mode == GA_STROBED && !mode_i.a_in) || mode_i.a_mode == GA_BIDIR;

  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      logic is_in;
      is_in      = (i >= HALF) ? mode_i.ch_in : mode_i.cl_in;
      pc_oe_o[i] = !is_in;
      pc_o[i]    = pc_q_i[i];
      pc_rd_o[i] = is_in ? pc_i[i] : pc_q_i[i];
    end
    if (mode_i.b_strobed) begin
      pc_oe_o[0] = 1'b1;
      pc_o[0]    = irq_b_i;
      pc_rd_o[0] = irq_b_i;
      pc_oe_o[1] = 1'b1;
      pc_o[1]    = mode_i.b_in ? ibf_b_i : obf_nb_i;
      pc_rd_o[1] = pc_o[1];
      pc_oe_o[2] = 1'b0;
      pc_rd_o[2] = inte_b_i;
    end
    if (a_hs) begin
      pc_oe_o[3] = 1'b1;
      pc_o[3]    = irq_a_i;
      pc_rd_o[3] = irq_a_i;
    end
    if (a_hs_in) begin
      pc_oe_o[4] = 1'b0;
      pc_rd_o[4] = inte_a_in_i;
      pc_oe_o[5] = 1'b1;
      pc_o[5]    = ibf_a_i;
      pc_rd_o[5] = ibf_a_i;
    end
    if (a_hs_out) begin
      pc_oe_o[6] = 1'b0;
      pc_rd_o[6] = inte_a_out_i;
      pc_oe_o[7] = 1'b1;
      pc_o[7]    = obf_na_i;
      pc_rd_o[7] = obf_na_i;
    end
  end
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  localparam int unsigned IDX_W = $clog2(PORT_W);

  mode_t             mode_q;
  logic [PORT_W-1:0] pa_q, pb_q, pc_q;
  logic              inte_a_in_q, inte_a_out_q, inte_b_q;

  logic wr_a, wr_b, wr_c, wr_ctl, rd_a, rd_b;
  logic mode_wr, bsr_wr;
  logic [IDX_W-1:0] bsr_idx;

  assign wr_a    = !cs_ni && wr_i && addr_i == ADR_PA;
  assign wr_b    = !cs_ni && wr_i && addr_i == ADR_PB;
  assign wr_c    = !cs_ni && wr_i && addr_i == ADR_PC;
  assign wr_ctl  = !cs_ni && wr_i && addr_i == ADR_CTL;
  assign rd_a    = !cs_ni && rd_i && addr_i == ADR_PA;
  assign rd_b    = !cs_ni && rd_i && addr_i == ADR_PB;
  assign mode_wr = wr_ctl && wdata_i[7];
  assign bsr_wr  = wr_ctl && !wdata_i[7];
  assign bsr_idx = wdata_i[IDX_W:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_RESET;
      pa_q         <= '0;
      pb_q         <= '0;
      pc_q         <= '0;
      inte_a_in_q  <= 1'b0;
      inte_a_out_q <= 1'b0;
      inte_b_q     <= 1'b0;
    end else if (mode_wr) begin
      mode_q       <= decode_mode(wdata_i);
      pa_q         <= '0;
      pb_q         <= '0;
      pc_q         <= '0;
      inte_a_in_q  <= 1'b0;
      inte_a_out_q <= 1'b0;
      inte_b_q     <= 1'b0;
    end else begin
      if (wr_a) pa_q <= wdata_i;
      if (wr_b) pb_q <= wdata_i;
      if (wr_c) pc_q <= wdata_i;
      if (bsr_wr) begin
        pc_q[bsr_idx] <= wdata_i[0];
        if (bsr_idx == IDX_W'(4)) inte_a_in_q  <= wdata_i[0];
        if (bsr_idx == IDX_W'(6)) inte_a_out_q <= wdata_i[0];
        if (bsr_idx == IDX_W'(2)) inte_b_q     <= wdata_i[0];
      end
    end
  end

  logic a_hs_in, a_hs_out, b_hs_in, b_hs_out;
  assign a_hs_in  = (mode_q.a_mode == GA_STROBED && mode_q.a_in) || mode_q.a_mode == GA_BIDIR;
  assign a_hs_out = (mode_q.a_mode == GA_STROBED && !mode_q.a_in) || mode_q.a_mode == GA_BIDIR;
  assign b_hs_in  = mode_q.b_strobed && mode_q.b_in;
  assign b_hs_out = mode_q.b_strobed && !mode_q.b_in;

  logic [PORT_W-1:0] a_in_q, b_in_q;
  logic ibf_a, obf_na, irq_a_in, irq_a_out;
  logic ibf_b, obf_nb, irq_b_in, irq_b_out;

  ppi_hs_chan #(.DATA_W(PORT_W)) u_chan_a (
    .clk_i, .rst_ni,
    .clr_i     (mode_wr),
    .in_en_i   (a_hs_in),
    .out_en_i  (a_hs_out),
    .stb_ni    (pc_i[4]),
    .ack_ni    (pc_i[6]),
    .din_i     (pa_i),
    .host_rd_i (rd_a),
    .host_wr_i (wr_a),
    .inte_in_i (inte_a_in_q),
    .inte_out_i(inte_a_out_q),
    .in_q_o    (a_in_q),
    .ibf_o     (ibf_a),
    .obf_no    (obf_na),
    .irq_in_o  (irq_a_in),
    .irq_out_o (irq_a_out)
  );

  ppi_hs_chan #(.DATA_W(PORT_W)) u_chan_b (
    .clk_i, .rst_ni,
    .clr_i     (mode_wr),
    .in_en_i   (b_hs_in),
    .out_en_i  (b_hs_out),
    .stb_ni    (pc_i[2]),
    .ack_ni    (pc_i[2]),
    .din_i     (pb_i),
    .host_rd_i (rd_b),
    .host_wr_i (wr_b),
    .inte_in_i (inte_b_q),
    .inte_out_i(inte_b_q),
    .in_q_o    (b_in_q),
    .ibf_o     (ibf_b),
    .obf_no    (obf_nb),
    .irq_in_o  (irq_b_in),
    .irq_out_o (irq_b_out)
  );

  logic [PORT_W-1:0] pc_rd;

  ppi_portc_map u_pcmap (
    .mode_i      (mode_q),
    .pc_q_i      (pc_q),
    .pc_i        (pc_i),
    .ibf_a_i     (ibf_a),
    .obf_na_i    (obf_na),
    .irq_a_i     (irq_a_in | irq_a_out),
    .inte_a_in_i (inte_a_in_q),
    .inte_a_out_i(inte_a_out_q),
    .ibf_b_i     (ibf_b),
    .obf_nb_i    (obf_nb),
    .irq_b_i     (irq_b_in | irq_b_out),
    .inte_b_i    (inte_b_q),
    .pc_o        (pc_o),
    .pc_oe_o     (pc_oe_o),
    .pc_rd_o     (pc_rd)
  );

  // port A/B pad drive and readback
  logic [PORT_W-1:0] pa_rd, pb_rd;

  always_comb begin
    pa_o = pa_q;
    unique case (mode_q.a_mode)
      GA_BIDIR: begin
        pa_oe_o = pc_i[6] ? '0 : '1;
        pa_rd   = a_in_q;
      end
      GA_STROBED: begin
        pa_oe_o = mode_q.a_in ? '0 : '1;
        pa_rd   = mode_q.a_in ? a_in_q : pa_q;
      end
      default: begin
        pa_oe_o = mode_q.a_in ? '0 : '1;
        pa_rd   = mode_q.a_in ? pa_i : pa_q;
      end
    endcase
    pb_o    = pb_q;
    pb_oe_o = mode_q.b_in ? '0 : '1;
    if (mode_q.b_in) pb_rd = mode_q.b_strobed ? b_in_q : pb_i;
    else             pb_rd = pb_q;
  end

  always_comb begin
    rdata_o = '0;
    if (!cs_ni && rd_i) begin
      unique case (addr_i)
        ADR_PA:  rdata_o = pa_rd;
        ADR_PB:  rdata_o = pb_rd;
        ADR_PC:  rdata_o = pc_rd;
        default: rdata_o = '1;
      endcase
    end
  end
endmodule

// File: rtl/ppi_ctrl_chk.sv
module ppi_ctrl_chk
  import ppi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [PORT_W-1:0] wdata_i,
  input logic [PORT_W-1:0] rdata_o,
  input logic [PORT_W-1:0] pa_o,
  input logic [PORT_W-1:0] pa_oe_o,
  input logic [PORT_W-1:0] pb_o,
  input logic [PORT_W-1:0] pc_i,
  input logic [PORT_W-1:0] pc_o,
  input mode_t             mode_q
);
  logic ctl_wr;
  assign ctl_wr = !cs_ni && wr_i && addr_i == ADR_CTL;

  a_r2_idle_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> rdata_o == '0);

  a_r2_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(pa_o) && $stable(pb_o));

  a_r3_ctl_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && rd_i && addr_i == ADR_CTL) |-> rdata_o == '1);

  a_r4_mode_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && wdata_i[7]) |=> pa_o == '0 && pb_o == '0);

  a_r7_strobe_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.a_mode == GA_STROBED && mode_q.a_in && !pc_i[4] && !ctl_wr) |=> pc_o[5]);

  a_r8_write_obf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && wr_i && addr_i == ADR_PA && mode_q.a_mode == GA_STROBED
     && !mode_q.a_in && pc_i[6]) |=> !pc_o[7]);

  a_r10_bidir_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.a_mode == GA_BIDIR && pc_i[6]) |-> pa_oe_o == '0);
endmodule

bind ppi_ctrl ppi_ctrl_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_ni  (cs_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .pa_o   (pa_o),
  .pa_oe_o(pa_oe_o),
  .pb_o   (pb_o),
  .pc_i   (pc_i),
  .pc_o   (pc_o),
  .mode_q (mode_q)
);

// File: tb/sim_ppi_ctrl.sv
`timescale 1ns/1ps
module sim_ppi_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] pa_i = '0, pa_o, pa_oe_o;
  logic [7:0] pb_i = '0, pb_o, pb_oe_o;
  logic [7:0] pc_i = 8'hFF, pc_o, pc_oe_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  ppi_ctrl u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    cs_ni = 1'b0; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_ni = 1'b1; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    cs_ni = 1'b0; rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    cs_ni = 1'b1; rd_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pa_oe", pa_oe_o, 8'h00);
    chk("R1 pb_oe", pb_oe_o, 8'h00);
    chk("R1 pc_oe", pc_oe_o, 8'h00);
    chk("R1 pa_o", pa_o, 8'h00);
    chk("R1 rdata", rdata_o, 8'h00);
  endtask

  task automatic t_simple;
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    chk("R4 all out pa_oe", pa_oe_o, 8'hFF);
    chk("R4 all out pc_oe", pc_oe_o, 8'hFF);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hA5);
    chk("R6 pa_o latch", pa_o, 8'h5A);
    chk("R6 pb_o latch", pb_o, 8'hA5);
    bus_rd(2'd0, d); chk("R3 R6 read A out", d, 8'h5A);
    bus_rd(2'd3, d); chk("R3 ctl read", d, 8'hFF);
    // deselected accesses
    wr_i = 1'b1; addr_i = 2'd0; wdata_i = 8'h11;
    @(negedge clk_i);
    addr_i = 2'd3; wdata_i = 8'h9B;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b1; addr_i = 2'd0;
    #1 chk("R2 rdata deselected", rdata_o, 8'h00);
    @(negedge clk_i); rd_i = 1'b0;
    chk("R2 pa_o kept", pa_o, 8'h5A);
    chk("R2 mode kept", pa_oe_o, 8'hFF);
    // A in, C upper out, B out, C lower in
    bus_wr(2'd3, 8'h91);
    chk("R4 latch cleared", pa_o, 8'h00);
    chk("R4 A input", pa_oe_o, 8'h00);
    chk("R6 C halves", pc_oe_o, 8'hF0);
    pa_i = 8'h3C; bus_rd(2'd0, d); chk("R6 live in 1", d, 8'h3C);
    pa_i = 8'hC3; bus_rd(2'd0, d); chk("R6 live in 2", d, 8'hC3);
    bus_wr(2'd2, 8'hA5);
    chk("R6 C upper out", pc_o & 8'hF0, 8'hA0);
    pc_i = 8'h06; bus_rd(2'd2, d); chk("R6 C mixed read", d, 8'hA6);
    pc_i = 8'hFF;
    bus_wr(2'd3, 8'h0D);
    chk("R5 set PC6", pc_o & 8'hF0, 8'hE0);
    bus_wr(2'd3, 8'h0E);
    chk("R5 clear PC7", pc_o & 8'hF0, 8'h60);
    chk("R5 mode kept pc_oe", pc_oe_o, 8'hF0);
    chk("R5 mode kept pa_oe", pa_oe_o, 8'h00);
  endtask

  task automatic t_a_strobed_in;
    logic [7:0] d;
    bus_wr(2'd3, 8'hB0);
    bus_wr(2'd3, 8'h09);
    pa_i = 8'h77; pc_i[4] = 1'b0;
    @(negedge clk_i);
    chk("R7 ibf set, no irq yet", pc_o & 8'h28, 8'h20);
    pc_i[4] = 1'b1; pa_i = 8'h00;
    @(negedge clk_i);
    chk("R7 irq on strobe rise", pc_o & 8'h28, 8'h28);
    bus_rd(2'd2, d); chk("R11 C status A in", d, 8'h38);
    bus_rd(2'd0, d); chk("R7 latched data", d, 8'h77);
    chk("R7 read clears", pc_o & 8'h28, 8'h00);
    // mode rewrite drops the enable
    bus_wr(2'd3, 8'hB0);
    pc_i[4] = 1'b0; @(negedge clk_i);
    pc_i[4] = 1'b1; @(negedge clk_i);
    chk("R4 R7 enable cleared, no irq", pc_o & 8'h28, 8'h20);
  endtask

  task automatic t_a_strobed_out;
    logic [7:0] d;
    bus_wr(2'd3, 8'hA0);
    chk("R8 obf idle", pc_o & 8'h88, 8'h80);
    chk("R8 pc_oe", pc_oe_o, 8'hBF);
    bus_wr(2'd3, 8'h0D);
    bus_wr(2'd0, 8'h3E);
    chk("R8 obf low", pc_o & 8'h80, 8'h00);
    chk("R8 data out", pa_o, 8'h3E);
    pc_i[6] = 1'b0; @(negedge clk_i);
    chk("R8 ack releases obf", pc_o & 8'h88, 8'h80);
    pc_i[6] = 1'b1; @(negedge clk_i);
    chk("R8 irq on ack rise", pc_o & 8'h88, 8'h88);
    bus_rd(2'd2, d); chk("R11 C status A out", d, 8'hC8);
    bus_wr(2'd0, 8'h01);
    chk("R8 write clears irq", pc_o & 8'h88, 8'h00);
  endtask

  task automatic t_b_strobed;
    logic [7:0] d;
    bus_wr(2'd3, 8'h86);
    chk("R9 pc_oe B in", pc_oe_o, 8'hFB);
    bus_wr(2'd3, 8'h05);
    pb_i = 8'h9D; pc_i[2] = 1'b0; @(negedge clk_i);
    chk("R9 ibf B", pc_o & 8'h03, 8'h02);
    pc_i[2] = 1'b1; pb_i = 8'h00; @(negedge clk_i);
    chk("R9 irq B", pc_o & 8'h03, 8'h03);
    bus_wr(2'd0, 8'h42);
    chk("R12 A plain out beside B strobed", pa_o, 8'h42);
    chk("R12 A oe", pa_oe_o, 8'hFF);
    bus_rd(2'd2, d); chk("R11 C status B in", d, 8'h07);
    bus_rd(2'd1, d); chk("R9 B latched", d, 8'h9D);
    chk("R9 read clears B", pc_o & 8'h03, 8'h00);
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd3, 8'h05);
    bus_wr(2'd1, 8'h21);
    chk("R9 obf B low", pc_o & 8'h03, 8'h00);
    chk("R9 B data", pb_o, 8'h21);
    pc_i[2] = 1'b0; @(negedge clk_i);
    chk("R9 ack B", pc_o & 8'h03, 8'h02);
    pc_i[2] = 1'b1; @(negedge clk_i);
    chk("R9 irq B out", pc_o & 8'h03, 8'h03);
  endtask

  task automatic t_bidir;
    logic [7:0] d;
    bus_wr(2'd3, 8'hC0);
    chk("R10 released", pa_oe_o, 8'h00);
    bus_wr(2'd0, 8'h5C);
    chk("R10 obf low", pc_o & 8'h80, 8'h00);
    chk("R10 no drive w/o ack", pa_oe_o, 8'h00);
    pc_i[6] = 1'b0;
    #1 chk("R10 drive on ack", pa_oe_o, 8'hFF);
    chk("R10 out data", pa_o, 8'h5C);
    @(negedge clk_i);
    chk("R10 obf released", pc_o & 8'h80, 8'h80);
    pc_i[6] = 1'b1;
    #1 chk("R10 release on ack high", pa_oe_o, 8'h00);
    pa_i = 8'hE1; pc_i[4] = 1'b0; @(negedge clk_i);
    chk("R10 ibf", pc_o & 8'h20, 8'h20);
    pc_i[4] = 1'b1; pa_i = 8'h00; @(negedge clk_i);
    chk("R10 no irq without enable", pc_o & 8'h08, 8'h00);
    bus_rd(2'd0, d); chk("R10 latched in", d, 8'hE1);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_simple();
    t_a_strobed_in();
    t_a_strobed_out();
    t_b_strobed();
    t_bidir();
    summary();
    $finish;
  end
endmodule